// File: doc/BRIEF.md
# Short-Vector Register Address Sequencer

This block turns one short-vector floating-point operation into a series of register-file addresses, one set per element. On a start pulse it captures three base register numbers (destination, first source, second source), the precision, a two-bit stride code and the vector length. It then produces one iteration per clock. Each iteration carries a destination, first-source and second-source address, a valid strobe and the iteration index. The index lets the neighbouring exception logic rewrite its saved copy of the instruction so that the copy points at the failing element.

The register file has four banks. In single precision a bank holds eight registers, so a 5-bit register number has its bank in bits 4:3 and its offset in bits 2:0. In double precision a bank holds four registers, the register number is 4 bits wide, its bank is in bits 3:2 and its offset in bits 1:0. An address moves forward by the stride and wraps at the end of its bank, so it never leaves the bank of its base register. When the second-source base lies in bank 0, that operand is a scalar and keeps the same address for the whole operation. Two of the four stride codes are reserved. A start with a reserved code produces no addresses and ends with an error flag.

Top module: `svseq_top`

## Requirements
- R1: After reset, addrValid, done, strideErr and busy are 0 and iterIdx is 0.
- R2: A start taken while idle with stride code 00 or 11 makes addrValid high on the next cycle. It stays high for exactly vecLenM1+1 consecutive cycles while iterIdx counts 0, 1, 2 and so on. done is high only together with the last valid cycle.
- R3: In single precision (isDouble=0), each address keeps bits 4:3 of its base. Its bits 2:0 equal (base[2:0] + i*step) mod 8 on iteration i.
- R4: In double precision (isDouble=1), the base register number is base[3:0] and input bit 4 is ignored. Each output has bit 4 at 0, keeps bits 3:2 of the base, and has bits 1:0 equal to (base[1:0] + i*step) mod 4.
- R5: Stride code 00 gives step 1. Stride code 11 gives step 2.
- R6: A second-source base in bank 0 is held on mAddr for every iteration. Bank 0 means baseM < 8 in single precision, or baseM[3:0] < 4 in double precision. The destination and first-source addresses are never held this way.
- R7: A length of one (vecLenM1=0) gives a single valid cycle that carries the unmodified base addresses, with done high in that same cycle.
- R8: A start with stride code 01 or 10 never raises addrValid. On the next cycle done and strideErr are both high for one cycle, and the block is idle afterwards.
- R9: A start pulse seen while busy is ignored, and the running sequence continues unchanged.
- R10: All operands are captured at the accepted start. Changes to isDouble, strideCode, vecLenM1 or the bases during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| isDouble | input | 1 | 1 = double precision, 0 = single |
| strideCode | input | 2 | 00 step 1, 11 step 2, others reserved |
| vecLenM1 | input | 3 | Vector length minus one |
| baseD | input | 5 | Destination base register |
| baseN | input | 5 | First-source base register |
| baseM | input | 5 | Second-source base register |
| dAddr | output | 5 | Destination address for current iteration |
| nAddr | output | 5 | First-source address for current iteration |
| mAddr | output | 5 | Second-source address for current iteration |
| addrValid | output | 1 | Addresses valid this cycle |
| iterIdx | output | 3 | Index of current iteration |
| done | output | 1 | Last iteration or reserved-stride completion |
| strideErr | output | 1 | Reserved stride code seen, with done |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench targets bases near the top of a bank with step 2. An adder that carries into the bank bits would then send the address into the next bank, and a double-precision sequence that wraps at 8 instead of 4 would show up the same way. It checks second-source bases just inside and just outside bank 0: a wrong bank-0 test either freezes a real vector operand or steps a scalar. Reserved stride codes, length one and length eight expose off-by-one errors in the iteration counter and a missing or doubled done. Inputs are scrambled and start is re-pulsed during runs, which catches operands that are read live instead of captured, and catches a restart taken while busy.

// File: rtl/svseq_pkg.sv
package svseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ERR  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;  // capture operands, clear offset
    logic step;  // advance offset by stride
  } ctrlStrobes_t;
endpackage

// File: rtl/svseq_ctrl.sv
module svseq_ctrl
  import svseq_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       strideCode,
  input  logic [LEN_W-1:0] vecLenM1,
  output ctrlStrobes_t     strobes,
  output logic             addrValid,
  output logic [LEN_W-1:0] iterIdx,
  output logic             done,
  output logic             strideErr,
  output logic             busy
);
  seqState_t stateQ, stateD;
  logic [LEN_W-1:0] cntQ, lenQ;
  logic strideOk, lastIter;

  assign strideOk = (strideCode == 2'b00) || (strideCode == 2'b11);
  assign lastIter = (cntQ == lenQ);

  always_comb begin
    stateD       = stateQ;
    strobes      = '0;
    case (stateQ)
      ST_IDLE: if (start) begin
        strobes.load = strideOk;
        stateD       = strideOk ? ST_RUN : ST_ERR;
      end
      ST_RUN: begin
        if (lastIter) stateD = ST_IDLE;
        else          strobes.step = 1'b1;
      end
      ST_ERR:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      lenQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (strobes.load) begin
        cntQ <= '0;
        lenQ <= vecLenM1;
      end else if (strobes.step) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign addrValid = (stateQ == ST_RUN);
  assign iterIdx   = addrValid ? cntQ : '0;
  assign strideErr = (stateQ == ST_ERR);
  assign done      = (addrValid && lastIter) || strideErr;
  assign busy      = (stateQ != ST_IDLE);
endmodule

// File: rtl/svseq_opnd.sv
module svseq_opnd #(
  parameter int ADDR_W     = 5,
  parameter int OFF_W      = 3,
  parameter bit CAN_FREEZE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic              isDouble,
  input  logic              dblQ,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] MASK_SP = ADDR_W'((1 << OFF_W) - 1);
  localparam logic [ADDR_W-1:0] MASK_DP = ADDR_W'((1 << (OFF_W - 1)) - 1);

  logic [ADDR_W-1:0] baseQ, mask, offExt, sum;
  logic frozen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     baseQ <= '0;
    else if (load) baseQ <= isDouble ? {1'b0, baseIn[ADDR_W-2:0]} : baseIn;
  end

  assign mask   = dblQ ? MASK_DP : MASK_SP;
  assign offExt = {{(ADDR_W-OFF_W){1'b0}}, offset};
  assign sum    = baseQ + offExt;

  generate
    if (CAN_FREEZE) begin : g_frz
      assign frozen = ((baseQ & ~mask) == '0);
    end else begin : g_nofrz
      assign frozen = 1'b0;
    end
  endgenerate

  assign addr = frozen ? baseQ : ((baseQ & ~mask) | (sum & mask));
endmodule

// File: rtl/svseq_dpath.sv
module svseq_dpath
  import svseq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              isDouble,
  input  logic [1:0]        strideCode,
  input  logic [ADDR_W-1:0] baseD,
  input  logic [ADDR_W-1:0] baseN,
  input  logic [ADDR_W-1:0] baseM,
  output logic [ADDR_W-1:0] dAddr,
  output logic [ADDR_W-1:0] nAddr,
  output logic [ADDR_W-1:0] mAddr
);
  localparam int NUM_OPND = 3;

  logic              dblQ;
  logic [OFF_W-1:0]  offQ, stepQ;
  logic [ADDR_W-1:0] baseAll [NUM_OPND];
  logic [ADDR_W-1:0] addrAll [NUM_OPND];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dblQ  <= 1'b0;
      offQ  <= '0;
      stepQ <= '0;
    end else if (strobes.load) begin
      dblQ  <= isDouble;
      offQ  <= '0;
      stepQ <= (strideCode == 2'b11) ? OFF_W'(2) : OFF_W'(1);
    end else if (strobes.step) begin
      offQ  <= offQ + stepQ;
    end
  end

  assign baseAll[0] = baseD;
  assign baseAll[1] = baseN;
  assign baseAll[2] = baseM;

  generate
    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
      svseq_opnd #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .CAN_FREEZE(g == NUM_OPND - 1)
      ) opnd_i (
        .clk(clk), .rstN(rstN), .load(strobes.load), .baseIn(baseAll[g]),
        .isDouble(isDouble), .dblQ(dblQ), .offset(offQ), .addr(addrAll[g])
      );
    end
  endgenerate

  assign dAddr = addrAll[0];
  assign nAddr = addrAll[1];
  assign mAddr = addrAll[2];
endmodule

// File: rtl/svseq_top.sv
module svseq_top
  import svseq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_REGS = 8,
  parameter int MAX_LEN   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isDouble,
  input  logic [1:0] strideCode,
  input  logic [2:0] vecLenM1,
  input  logic [4:0] baseD,
  input  logic [4:0] baseN,
  input  logic [4:0] baseM,
  output logic [4:0] dAddr,
  output logic [4:0] nAddr,
  output logic [4:0] mAddr,
  output logic       addrValid,
  output logic [2:0] iterIdx,
  output logic       done,
  output logic       strideErr,
  output logic       busy
);
  localparam int ADDR_W = $clog2(NUM_BANKS * BANK_REGS);
  localparam int OFF_W  = $clog2(BANK_REGS);
  localparam int LEN_W  = $clog2(MAX_LEN);

  ctrlStrobes_t strobes;

  svseq_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .strideCode(strideCode),
    .vecLenM1(vecLenM1), .strobes(strobes), .addrValid(addrValid),
    .iterIdx(iterIdx), .done(done), .strideErr(strideErr), .busy(busy)
  );

  svseq_dpath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .isDouble(isDouble),
    .strideCode(strideCode), .baseD(baseD), .baseN(baseN), .baseM(baseM),
    .dAddr(dAddr), .nAddr(nAddr), .mAddr(mAddr)
  );
endmodule

// File: rtl/svseq_chk.sv
module svseq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] dAddr,
  input logic [4:0] nAddr,
  input logic       addrValid,
  input logic [2:0] iterIdx,
  input logic       done,
  input logic       strideErr
);
  // R8
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && strideErr));

  // R2
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (addrValid || strideErr));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  iter_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !done) |=> (addrValid && iterIdx == $past(iterIdx) + 3'd1));

  // R2
  iter_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrValid) |-> (iterIdx == 3'd0));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !done) |=> ($stable(dAddr[4:3]) && $stable(nAddr[4:3])));
endmodule

bind svseq_top svseq_chk chk_i (
  .clk(clk), .rstN(rstN), .dAddr(dAddr), .nAddr(nAddr),
  .addrValid(addrValid), .iterIdx(iterIdx), .done(done), .strideErr(strideErr)
);

// File: tb/svseq_tb.sv
module svseq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, isDouble = 1'b0;
  logic [1:0] strideCode = 2'b00;
  logic [2:0] vecLenM1 = 3'd0;
  logic [4:0] baseD = '0, baseN = '0, baseM = '0;
  logic [4:0] dAddr, nAddr, mAddr;
  logic addrValid, done, strideErr, busy;
  logic [2:0] iterIdx;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svseq_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .isDouble(isDouble),
    .strideCode(strideCode), .vecLenM1(vecLenM1), .baseD(baseD),
    .baseN(baseN), .baseM(baseM), .dAddr(dAddr), .nAddr(nAddr),
    .mAddr(mAddr), .addrValid(addrValid), .iterIdx(iterIdx), .done(done),
    .strideErr(strideErr), .busy(busy)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expAddr(logic [4:0] base, bit dbl, int step, int i, bit freeze);
    int bsz = dbl ? 4 : 8;
    int b = dbl ? int'(base[3:0]) : int'(base);
    if (freeze && b < bsz) return b;
    return (b / bsz) * bsz + ((b % bsz) + i * step) % bsz;
  endfunction

  // R2 R3 R4 R5 R6 R7 R9 R10: run one sequence, optionally scrambling inputs
  task automatic runSeq(bit dbl, logic [1:0] sc, logic [2:0] lm1,
                        logic [4:0] d, logic [4:0] n, logic [4:0] m, bit scramble);
    int step = (sc == 2'b11) ? 2 : 1;
    int len = int'(lm1) + 1;
    isDouble = dbl; strideCode = sc; vecLenM1 = lm1;
    baseD = d; baseN = n; baseM = m; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      chk("R2", "addrValid", addrValid, 1);
      chk("R2", "iterIdx", iterIdx, i);
      chk("R2", "done", done, (i == len - 1));
      chk(dbl ? "R4" : "R3", "dAddr", dAddr, expAddr(d, dbl, step, i, 0));
      chk(dbl ? "R4" : "R3", "nAddr", nAddr, expAddr(n, dbl, step, i, 0));
      chk("R6", "mAddr", mAddr, expAddr(m, dbl, step, i, 1));
      if (scramble && i < len - 1) begin
        // R9 R10: noise on every input, including start
        start = 1'($urandom); isDouble = 1'($urandom);
        strideCode = 2'($urandom); vecLenM1 = 3'($urandom);
        baseD = 5'($urandom); baseN = 5'($urandom); baseM = 5'($urandom);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk("R2", "addrValid after end", addrValid, 0);
    chk("R9", "busy after end", busy, 0);
  endtask

  // R8
  task automatic runErr(logic [1:0] sc);
    strideCode = sc; vecLenM1 = 3'($urandom); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R8", "addrValid", addrValid, 0);
    chk("R8", "done", done, 1);
    chk("R8", "strideErr", strideErr, 1);
    @(negedge clk);
    chk("R8", "done clear", done, 0);
    chk("R8", "strideErr clear", strideErr, 0);
    chk("R8", "addrValid idle", addrValid, 0);
    chk("R8", "busy idle", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "addrValid", addrValid, 0);
    chk("R1", "done", done, 0);
    chk("R1", "strideErr", strideErr, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "iterIdx", iterIdx, 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runSeq(0, 2'b00, 3'd7, 5'd5, 5'd14, 5'd3, 0);    // R3 wrap, R6 frozen
    runSeq(0, 2'b11, 3'd7, 5'd31, 5'd7, 5'd8, 0);    // R5 step 2, R6 not frozen at 8
    runSeq(1, 2'b11, 3'd5, 5'd19, 5'd6, 5'd3, 0);    // R4 bit4 ignored, R6 frozen
    runSeq(1, 2'b00, 3'd7, 5'd15, 5'd2, 5'd4, 0);    // R4 mod 4, R6 not frozen at 4
    runSeq(0, 2'b11, 3'd0, 5'd29, 5'd1, 5'd22, 0);   // R7 length one
    runErr(2'b01);
    runErr(2'b10);
    runSeq(0, 2'b00, 3'd6, 5'd12, 5'd27, 5'd17, 1);  // R9 R10
    // random mix
    for (int k = 0; k < 300; k++) begin
      if (($urandom % 10) == 0) runErr(($urandom % 2) ? 2'b01 : 2'b10);
      else runSeq(1'($urandom), ($urandom % 2) ? 2'b11 : 2'b00, 3'($urandom),
                  5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
      if (($urandom % 4) == 0) @(negedge clk);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule